// File: doc/BRIEF.md
# Prescaled 16-bit Up/Down Timer-Counter with Auto-Reload

This block is a 16-bit counter that advances either on internal clock ticks or on falling edges of an external input pin. In timer mode a 2-bit field selects a clock divide of 1, 2, 4 or 8 ahead of the counter. In event mode every clean high-to-low transition of the pin moves the count by one, whatever the divide field says. A run control starts and freezes counting.

The counter can run upward or downward. A 16-bit reload value, written one byte at a time, is loaded automatically when the count wraps. Counting up, the step after all-ones loads the reload value. Counting down, the step taken while the count equals the reload value loads all-ones. Either wrap sets a sticky flag, and software clears that flag with a one-cycle clear strobe. The current count and the flag leave the block from registers.

Top module: `tick_timer16`

## Requirements
- R1: A synchronous active-high reset sets the count, the flag and the reload value to zero.
- R2: In timer mode (`ext_sel`=0) with `psel`=00 and `run`=1, the count moves by one on every clock edge.
- R3: The `psel` field divides the timer clock: 00 by 1, 01 by 2, 10 by 4, 11 by 8. When `run` rises, the first step comes after a full divide period, so N edges with `run`=1 give floor(N/divide) steps.
- R4: While `run`=0 the count holds its value and the prescaler returns to zero. A run period shorter than one divide period therefore never produces a step, even when several such periods are added together.
- R5: In event mode (`ext_sel`=1) the clock is not counted. Each 1-to-0 transition of `ext_pin` adds exactly one step, three clock edges after the pin falls, and `psel` has no effect. Rising edges and a steady level add nothing.
- R6: `rld_we[0]` writes `rld_wdata` into the low byte of the reload value and `rld_we[1]` writes it into the high byte. A write does not change the count or the flag.
- R7: Counting up (`count_down`=0), the step taken at 16'hFFFF loads the reload value and sets `wrap_flag`. Other up steps add one and leave the flag unchanged.
- R8: Counting down (`count_down`=1), the step taken while the count equals the reload value loads 16'hFFFF and sets `wrap_flag`. Other down steps subtract one.
- R9: `wrap_flag` stays set until `flag_clr` is pulsed. A wrap in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Counting enable |
| ext_sel | input | 1 | 1 selects event mode (pin falling edges), 0 selects timer mode |
| psel | input | 2 | Timer clock divide select |
| count_down | input | 1 | 1 counts down, 0 counts up |
| rld_we | input | 2 | Per-byte reload write enables (bit 0 low byte, bit 1 high byte) |
| rld_wdata | input | 8 | Reload write data |
| ext_pin | input | 1 | Asynchronous external event input |
| flag_clr | input | 1 | Clear strobe for the wrap flag |
| count_q | output | 16 | Current count |
| wrap_flag | output | 1 | Sticky overflow/underflow flag |

## Verification
A wrong prescaler phase shows up at `count_q` as a step count that is off by one at the end of a run window. It appears within one divide period, at most eight edges. A wrong wrap compare or reload load shows up on the first step after the count reaches the boundary: `count_q` holds a wrong value and `wrap_flag` is wrong in the next cycle. A fault in the pin synchroniser shows up as a step that arrives at the wrong edge, or as a missing or extra step on a rising edge. Each of these is visible within three edges of the pin change.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int TT_BYTE_W = 8;

  typedef enum logic {
    TT_MODE_TIMER = 1'b0,
    TT_MODE_EVENT = 1'b1
  } tt_mode_e;
endpackage

// File: rtl/tt_edge_sync.sv
module tt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh[0] <= 1'b1;
    else     sh[0] <= pin;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sh[i] <= 1'b1;
      else     sh[i] <= sh[i-1];
    end
  end

  // previous synchronised sample high, current one low
  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/tt_prescale.sv
module tt_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pc;
  logic [PC_W:0]   div_w;
  logic [PC_W:0]   lim_w;
  logic [PC_W-1:0] lim;
  logic            at_lim;

  always_comb begin
    div_w  = (PC_W+1)'(1) << sel;
    lim_w  = div_w - (PC_W+1)'(1);
    lim    = lim_w[PC_W-1:0];
    at_lim = (pc >= lim);
  end

  assign tick = en & at_lim;

  always_ff @(posedge clk) begin
    if (rst || !en)  pc <= '0;
    else if (at_lim) pc <= '0;
    else             pc <= pc + PC_W'(1);
  end
endmodule

// File: rtl/tt_count16.sv
module tt_count16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         down,
  input  logic [W-1:0] rld,
  input  logic         clr_flag,
  output logic [W-1:0] cnt,
  output logic         flag
);
  logic up_wrap;
  logic dn_wrap;

  assign up_wrap = step & ~down & (cnt == {W{1'b1}});
  assign dn_wrap = step &  down & (cnt == rld);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (up_wrap) begin
      cnt <= rld;
    end else if (dn_wrap) begin
      cnt <= {W{1'b1}};
    end else if (step) begin
      cnt <= down ? cnt - W'(1) : cnt + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      flag <= 1'b0;
    else if (up_wrap || dn_wrap)  flag <= 1'b1;
    else if (clr_flag)            flag <= 1'b0;
  end
endmodule

// File: rtl/tick_timer16.sv
module tick_timer16 #(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2,
  localparam int BW         = tt_pkg::TT_BYTE_W,
  localparam int NB         = CNT_W / BW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ext_sel,
  input  logic [PS_W-1:0]  psel,
  input  logic             count_down,
  input  logic [NB-1:0]    rld_we,
  input  logic [BW-1:0]    rld_wdata,
  input  logic             ext_pin,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             wrap_flag
);
  import tt_pkg::*;

  logic [CNT_W-1:0] rld_q;
  logic             pin_fall;
  logic             ps_tick;
  logic             step;
  tt_mode_e         mode;

  assign mode = tt_mode_e'(ext_sel);

  for (genvar b = 0; b < NB; b++) begin : g_rld
    always_ff @(posedge clk) begin
      if (rst)            rld_q[b*BW +: BW] <= '0;
      else if (rld_we[b]) rld_q[b*BW +: BW] <= rld_wdata;
    end
  end

  tt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_pin),
    .fall (pin_fall)
  );

  tt_prescale #(.SEL_W(PS_W)) u_ps (
    .clk  (clk),
    .rst  (rst),
    .en   (run && (mode == TT_MODE_TIMER)),
    .sel  (psel),
    .tick (ps_tick)
  );

  assign step = (mode == TT_MODE_EVENT) ? (run & pin_fall) : ps_tick;

  tt_count16 #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .down     (count_down),
    .rld      (rld_q),
    .clr_flag (flag_clr),
    .cnt      (count_q),
    .flag     (wrap_flag)
  );
endmodule

// File: rtl/tt_timer16_chk.sv
module tt_timer16_chk #(
  parameter int W     = 16,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             ext_sel,
  input logic [SEL_W-1:0] psel,
  input logic             count_down,
  input logic             flag_clr,
  input logic [W-1:0]     count_q,
  input logic             wrap_flag,
  input logic [W-1:0]     rld_q
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count_q == '0 && !wrap_flag));

  p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !ext_sel && psel == '0 && !count_down && count_q != {W{1'b1}})
    |=> count_q == W'($past(count_q) + W'(1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(count_q));

  p_wrap_load_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(wrap_flag) |-> (count_q == {W{1'b1}} || count_q == $past(rld_q)));

  p_down_step_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !ext_sel && psel == '0 && count_down && count_q != rld_q)
    |=> count_q == W'($past(count_q) - W'(1)));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (wrap_flag && !flag_clr) |=> wrap_flag);
endmodule

bind tick_timer16 tt_timer16_chk #(.W(CNT_W), .SEL_W(PS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .run        (run),
  .ext_sel    (ext_sel),
  .psel       (psel),
  .count_down (count_down),
  .flag_clr   (flag_clr),
  .count_q    (count_q),
  .wrap_flag  (wrap_flag),
  .rld_q      (rld_q)
);

// File: tb/sim_tick_timer16.sv
`timescale 1ns/1ps
module sim_tick_timer16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        ext_sel = 1'b0;
  logic [1:0]  psel = 2'd0;
  logic        count_down = 1'b0;
  logic [1:0]  rld_we = 2'd0;
  logic [7:0]  rld_wdata = 8'd0;
  logic        ext_pin = 1'b1;
  logic        flag_clr = 1'b0;
  logic [15:0] count_q;
  logic        wrap_flag;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tick_timer16 u0 (
    .clk(clk), .rst(rst), .run(run), .ext_sel(ext_sel), .psel(psel),
    .count_down(count_down), .rld_we(rld_we), .rld_wdata(rld_wdata),
    .ext_pin(ext_pin), .flag_clr(flag_clr), .count_q(count_q),
    .wrap_flag(wrap_flag)
  );

  // {psel[15:14], run edges[13:8], expected count[7:0]}
  localparam logic [15:0] VEC [8] = '{
    {2'd0, 6'd10, 8'd10},
    {2'd1, 6'd10, 8'd5},
    {2'd2, 6'd10, 8'd2},
    {2'd3, 6'd10, 8'd1},
    {2'd3, 6'd7,  8'd0},
    {2'd3, 6'd17, 8'd2},
    {2'd2, 6'd3,  8'd0},
    {2'd1, 6'd1,  8'd0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1; run = 1'b0; ext_sel = 1'b0; psel = 2'd0; count_down = 1'b0;
    rld_we = 2'd0; flag_clr = 1'b0; ext_pin = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic pulse_clr;
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 count", 32'(count_q), 32'h0);
    chk("R1 flag", 32'(wrap_flag), 32'h0);

    // R3 / R2: prescale table
    for (int i = 0; i < 8; i++) begin
      do_reset();
      psel = VEC[i][15:14];
      run = 1'b1;
      step(int'(VEC[i][13:8]));
      run = 1'b0;
      chk($sformatf("R3 vec%0d", i), 32'(count_q), 32'(VEC[i][7:0]));
    end

    // R4: hold and prescaler restart
    do_reset();
    run = 1'b1; step(5); run = 1'b0;
    chk("R2 div1 count", 32'(count_q), 32'd5);
    step(5);
    chk("R4 hold", 32'(count_q), 32'd5);
    psel = 2'd2;
    run = 1'b1; step(3); run = 1'b0; step(2);
    run = 1'b1; step(3);
    chk("R4 prescaler restart", 32'(count_q), 32'd5);
    step(1);
    run = 1'b0;
    chk("R4 full period after restart", 32'(count_q), 32'd6);

    // R8 / R1: down from zero with reset reload of zero
    do_reset();
    count_down = 1'b1; run = 1'b1; step(1); run = 1'b0;
    chk("R8 underflow count", 32'(count_q), 32'hFFFF);
    chk("R8 underflow flag", 32'(wrap_flag), 32'h1);
    step(3);
    chk("R9 flag sticky", 32'(wrap_flag), 32'h1);
    pulse_clr();
    chk("R9 flag clear", 32'(wrap_flag), 32'h0);

    // R6: byte-wise reload writes
    rld_wdata = 8'h34; rld_we = 2'b01; step(1);
    rld_wdata = 8'h12; rld_we = 2'b10; step(1);
    rld_we = 2'b00;
    chk("R6 count untouched", 32'(count_q), 32'hFFFF);
    chk("R6 flag untouched", 32'(wrap_flag), 32'h0);

    // R7: up overflow loads reload
    count_down = 1'b0; run = 1'b1; step(1); run = 1'b0;
    chk("R7 overflow load", 32'(count_q), 32'h1234);
    chk("R7 overflow flag", 32'(wrap_flag), 32'h1);
    pulse_clr();
    run = 1'b1; step(3); run = 1'b0;
    chk("R7 plain up steps", 32'(count_q), 32'h1237);
    chk("R7 no flag on plain step", 32'(wrap_flag), 32'h0);

    // R8: down to reload then underflow
    count_down = 1'b1; run = 1'b1; step(3); run = 1'b0;
    chk("R8 down steps", 32'(count_q), 32'h1234);
    chk("R8 no flag yet", 32'(wrap_flag), 32'h0);
    run = 1'b1; step(1); run = 1'b0;
    chk("R8 reload match underflow", 32'(count_q), 32'hFFFF);
    chk("R8 flag", 32'(wrap_flag), 32'h1);
    pulse_clr();

    // R9: wrap and clear in the same cycle
    count_down = 1'b0; run = 1'b1; flag_clr = 1'b1; step(1);
    run = 1'b0; flag_clr = 1'b0;
    chk("R9 wrap count", 32'(count_q), 32'h1234);
    chk("R9 wrap beats clear", 32'(wrap_flag), 32'h1);

    // R5: event mode
    do_reset();
    ext_sel = 1'b1; psel = 2'd3; run = 1'b1;
    step(6);
    chk("R5 clock ignored", 32'(count_q), 32'd0);
    ext_pin = 1'b0; step(2);
    chk("R5 not yet", 32'(count_q), 32'd0);
    step(1);
    chk("R5 first edge", 32'(count_q), 32'd1);
    step(4);
    chk("R5 low level", 32'(count_q), 32'd1);
    ext_pin = 1'b1; step(4);
    chk("R5 rising edge", 32'(count_q), 32'd1);
    ext_pin = 1'b0; step(3);
    chk("R5 second edge", 32'(count_q), 32'd2);
    ext_pin = 1'b1; step(3);
    run = 1'b0; ext_pin = 1'b0; step(5);
    chk("R4 event mode hold", 32'(count_q), 32'd2);
    ext_pin = 1'b1; step(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule